// File: doc/BRIEF.md
# Peripheral Power-Domain and Local-SRAM Power Controller

This block sits in a chip's system-control area. It owns the power-domain enables of the peripherals that have their own switchable domain. It also owns the low-power state of each peripheral's local SRAM array. Software writes the controls through a simple register port. The chip's power manager raises `sleep` or `deep_sleep`. The switch fabric and the memory arrays answer each request with an acknowledge level, and the status words are built from these acknowledges.

The memory settings are sampled once, on the cycle in which deep-sleep is entered. A setting is honoured only when the peripheral has the matching capability:

- The USB slot can retain its array or power it down.
- The CAN slot can only power it down.
- The LCD slot can do neither.
- The EMAC slot can power its array down only when its own domain enable has been cleared.

If an array is powered down, it flags its contents as invalid. The flag stays set after wake-up until software clears it. A retained array stays blocked for one extra cycle after its acknowledge drops. The low-power regulator request is held back while a debugger is attached.

Slot map: 0 CAN, 1 LCD, 2 EMAC, 3 Ethernet PHY, 4 USB, 5 crypto. Slots 6 and 7 have no power domain of their own.

Top module: `periph_pwr_ctrl`

## Requirements
- R1: After reset, all `dom_req` bits are 1, `mem_ret`, `mem_off` and `mem_blk` are 0, every memory-mode register reads 1 and every status word reads 0x00.
- R2: A write to bank 0 (address bits [4:3] = 00, slot in bits [2:0]) of a slot with its own domain loads `wr_data[0]` into that slot's domain enable, which drives `dom_req` from the next cycle.
- R3: Bank 0 writes to slots 6 and 7 are ignored: `dom_req` stays 1 and bank 0 reads back 1.
- R4: Status bits [1:0] give the domain state: 00 when request and acknowledge are both 1, 10 when both are 0, 11 while they differ.
- R5: The bank 1 memory mode (bit 0: 1 = retain, 0 = power off) is evaluated only on the cycle deep-sleep is entered and is held until deep-sleep ends. Writes made during deep-sleep take effect at the next entry.
- R6: A retain selection on a retention-capable slot drives `mem_ret`. Status bits [3:2] read 01 once `mem_ack` is high, and `mem_blk` is high for as long as the array is not on.
- R7: A selection the slot cannot support leaves the array on: no `mem_ret`/`mem_off` request, status bits [3:2] = 00, no block.
- R8: A power-off selection drives `mem_off` on CAN and USB. On EMAC it does so only when EMAC's domain enable is 0 at entry. Status bits [3:2] read 10 once acknowledged.
- R9: An acknowledged power-off sets status bit 4 (contents invalid). The bit survives wake-up and is cleared by writing 1 to bit 0 of that slot's bank 2 address.
- R10: On wake-up, `mem_blk` stays high for exactly one cycle after `mem_ack` falls.
- R11: `ldo_lp_en` is high when `sleep` or `deep_sleep` is high and `dbg_attached` is low, and low otherwise.
- R12: A read is registered. `rd_valid` is high in the cycle after `rd_en`, and `rd_data` holds the addressed word: bank 0 domain enable, bank 1 mode, bank 2 status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address: bank [4:3], slot [2:0] |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 5 | Read address: bank [4:3], slot [2:0] |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | Read data valid |
| sleep | input | 1 | Sleep mode indication |
| deep_sleep | input | 1 | Deep-sleep mode indication |
| dbg_attached | input | 1 | Debugger connected |
| dom_ack | input | 8 | Per-slot domain powered acknowledge |
| mem_ack | input | 8 | Per-slot array in low-power state acknowledge |
| dom_req | output | 8 | Per-slot domain power request |
| mem_ret | output | 8 | Per-slot array retention request |
| mem_off | output | 8 | Per-slot array power-off request |
| mem_blk | output | 8 | Per-slot array access block |
| ldo_lp_en | output | 1 | Low-power regulator setting request |

## Verification
A wrong latched memory target shows up on `mem_ret`/`mem_off` one cycle after deep-sleep entry. The status word shows the same fault as soon as the plant acknowledges, so the bench reads status while the acks are frozen and again after they settle. A lost wake hold or a stale invalid flag appears only after exit. The bench counts the cycles of `mem_blk` after `deep_sleep` falls and reads status again after wake-up and after the clearing write.

// File: rtl/periph_pwr_pkg.sv
package periph_pwr_pkg;

  typedef enum logic [1:0] {
    PS_ON  = 2'b00,
    PS_RET = 2'b01,
    PS_OFF = 2'b10,
    PS_XN  = 2'b11
  } pstate_e;

  localparam logic [1:0] BK_DOM  = 2'd0;
  localparam logic [1:0] BK_MEM  = 2'd1;
  localparam logic [1:0] BK_STAT = 2'd2;

endpackage

// File: rtl/ppc_cfg_regs.sv
module ppc_cfg_regs
  import periph_pwr_pkg::*;
#(
  parameter int          NSLOT   = 8,
  parameter logic [7:0]  HAS_DOM = 8'h3F,
  parameter logic [7:0]  HAS_MEM = 8'h17,
  localparam int         SLOT_W  = $clog2(NSLOT),
  localparam int         ADDR_W  = SLOT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_bit,
  output logic [NSLOT-1:0]  dom_en,
  output logic [NSLOT-1:0]  mode_ret,
  output logic [NSLOT-1:0]  clr_inv
);

  logic [1:0]        wbank;
  logic [SLOT_W-1:0] wslot;

  assign wbank = wr_addr[ADDR_W-1:SLOT_W];
  assign wslot = wr_addr[SLOT_W-1:0];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic hit;
    assign hit        = wr_en && (wslot == SLOT_W'(g));
    assign clr_inv[g] = hit && (wbank == BK_STAT) && wr_bit;

    if (HAS_DOM[g]) begin : g_dom
      logic en_q, en_d, en_ce;
      assign en_ce = hit && (wbank == BK_DOM);
      always_comb begin
        en_d = en_q;
        if (en_ce) en_d = wr_bit;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b1;
        else        en_q <= en_d;
      end
      assign dom_en[g] = en_q;
    end else begin : g_nodom
      assign dom_en[g] = 1'b1;
    end

    if (HAS_MEM[g]) begin : g_mem
      logic md_q, md_d, md_ce;
      assign md_ce = hit && (wbank == BK_MEM);
      always_comb begin
        md_d = md_q;
        if (md_ce) md_d = wr_bit;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) md_q <= 1'b1;
        else        md_q <= md_d;
      end
      assign mode_ret[g] = md_q;
    end else begin : g_nomem
      assign mode_ret[g] = 1'b1;
    end
  end

endmodule

// File: rtl/ppc_dom_stat.sv
module ppc_dom_stat
  import periph_pwr_pkg::*;
#(
  parameter int NSLOT = 8
) (
  input  logic [NSLOT-1:0] dom_en,
  input  logic [NSLOT-1:0] dom_ack,
  output pstate_e          dstate [NSLOT]
);

  for (genvar g = 0; g < NSLOT; g++) begin : g_st
    always_comb begin
      if (dom_en[g] && dom_ack[g])        dstate[g] = PS_ON;
      else if (!dom_en[g] && !dom_ack[g]) dstate[g] = PS_OFF;
      else                                dstate[g] = PS_XN;
    end
  end

endmodule

// File: rtl/ppc_mem_slot.sv
module ppc_mem_slot
  import periph_pwr_pkg::*;
#(
  parameter bit RET_OK       = 1'b0,
  parameter bit PD_OK        = 1'b0,
  parameter bit PD_NEED_DOFF = 1'b0
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    deep_sleep,
  input  logic    ds_entry,
  input  logic    mode_ret,
  input  logic    dom_en,
  input  logic    mem_ack,
  input  logic    clr_inv,
  output logic    ret_req,
  output logic    off_req,
  output logic    blk,
  output pstate_e mstate,
  output logic    inv
);

  pstate_e tgt_q, tgt_d, pick;
  logic    ack_q;
  logic    inv_q, inv_d;

  always_comb begin
    pick = PS_ON;
    if (mode_ret) begin
      if (RET_OK) pick = PS_RET;
    end else if (PD_OK && (!PD_NEED_DOFF || !dom_en)) begin
      pick = PS_OFF;
    end
  end

  always_comb begin
    tgt_d = tgt_q;
    if (!deep_sleep)   tgt_d = PS_ON;
    else if (ds_entry) tgt_d = pick;
  end

  always_comb begin
    inv_d = inv_q;
    if (clr_inv) inv_d = 1'b0;
    if ((tgt_q == PS_OFF) && mem_ack) inv_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= PS_ON;
      ack_q <= 1'b0;
      inv_q <= 1'b0;
    end else begin
      tgt_q <= tgt_d;
      ack_q <= mem_ack;
      inv_q <= inv_d;
    end
  end

  assign ret_req = (tgt_q == PS_RET);
  assign off_req = (tgt_q == PS_OFF);
  assign blk     = (tgt_q != PS_ON) || mem_ack || ack_q;
  assign inv     = inv_q;

  always_comb begin
    if ((tgt_q == PS_ON) && !mem_ack)      mstate = PS_ON;
    else if ((tgt_q != PS_ON) && mem_ack)  mstate = tgt_q;
    else                                   mstate = PS_XN;
  end

  // R6
  lowpwr_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req || off_req) |-> blk);

  // R10
  wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ack) |-> blk);

  // R9
  off_marks_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (off_req && mem_ack) |=> inv);

  // R5
  mode_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(deep_sleep) && $past(deep_sleep, 2)) |-> $stable({ret_req, off_req}));

  // R7
  no_ret_wo_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !RET_OK |-> !ret_req);

endmodule

// File: rtl/periph_pwr_ctrl.sv
module periph_pwr_ctrl
  import periph_pwr_pkg::*;
#(
  parameter int         NSLOT        = 8,
  parameter logic [7:0] HAS_DOM      = 8'b0011_1111,
  parameter logic [7:0] HAS_MEM      = 8'b0001_0111,
  parameter logic [7:0] RET_CAP      = 8'b0001_0000,
  parameter logic [7:0] PD_CAP       = 8'b0001_0101,
  parameter logic [7:0] PD_NEED_DOFF = 8'b0000_0100,
  parameter int         DATA_W       = 8,
  localparam int        SLOT_W       = $clog2(NSLOT),
  localparam int        ADDR_W       = SLOT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              sleep,
  input  logic              deep_sleep,
  input  logic              dbg_attached,
  input  logic [NSLOT-1:0]  dom_ack,
  input  logic [NSLOT-1:0]  mem_ack,
  output logic [NSLOT-1:0]  dom_req,
  output logic [NSLOT-1:0]  mem_ret,
  output logic [NSLOT-1:0]  mem_off,
  output logic [NSLOT-1:0]  mem_blk,
  output logic              ldo_lp_en
);

  logic [NSLOT-1:0] dom_en, mode_ret, clr_inv, inv;
  pstate_e          dstate [NSLOT];
  pstate_e          mstate [NSLOT];
  logic             ds_q, ds_entry;
  logic             unused_wr_hi;

  assign unused_wr_hi = ^wr_data[DATA_W-1:1];

  ppc_cfg_regs #(
    .NSLOT(NSLOT), .HAS_DOM(HAS_DOM), .HAS_MEM(HAS_MEM)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_bit(wr_data[0]), .dom_en(dom_en), .mode_ret(mode_ret),
    .clr_inv(clr_inv)
  );

  ppc_dom_stat #(.NSLOT(NSLOT)) u_dstat (
    .dom_en(dom_en), .dom_ack(dom_ack), .dstate(dstate)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ds_q <= 1'b0;
    else        ds_q <= deep_sleep;
  end
  assign ds_entry = deep_sleep && !ds_q;

  for (genvar g = 0; g < NSLOT; g++) begin : g_mem
    ppc_mem_slot #(
      .RET_OK(RET_CAP[g]), .PD_OK(PD_CAP[g]), .PD_NEED_DOFF(PD_NEED_DOFF[g])
    ) u_slot (
      .clk(clk), .rst_n(rst_n), .deep_sleep(deep_sleep), .ds_entry(ds_entry),
      .mode_ret(mode_ret[g]), .dom_en(dom_en[g]), .mem_ack(mem_ack[g]),
      .clr_inv(clr_inv[g]), .ret_req(mem_ret[g]), .off_req(mem_off[g]),
      .blk(mem_blk[g]), .mstate(mstate[g]), .inv(inv[g])
    );
  end

  assign dom_req   = dom_en;
  assign ldo_lp_en = (sleep || deep_sleep) && !dbg_attached;

  logic [1:0]        rbank;
  logic [SLOT_W-1:0] rslot;
  logic [DATA_W-1:0] rd_d;
  logic              rv_d;

  assign rbank = rd_addr[ADDR_W-1:SLOT_W];
  assign rslot = rd_addr[SLOT_W-1:0];

  always_comb begin
    rd_d = '0;
    case (rbank)
      BK_DOM:  rd_d[0]   = dom_en[rslot];
      BK_MEM:  rd_d[0]   = mode_ret[rslot];
      BK_STAT: rd_d[4:0] = {inv[rslot], mstate[rslot], dstate[rslot]};
      default: rd_d      = '0;
    endcase
    rv_d = rd_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rv_d;
      if (rd_en) rd_data <= rd_d;
    end
  end

  // R12
  rd_valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

endmodule

// File: tb/periph_pwr_ctrl_bench.sv
`timescale 1ns/1ps
module periph_pwr_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, rd_en;
  logic [4:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic       rd_valid, sleep, deep_sleep, dbg_attached, ldo_lp_en;
  logic [7:0] dom_ack, mem_ack, dom_req, mem_ret, mem_off, mem_blk;
  logic       hold_ack;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #4 clk = ~clk;

  periph_pwr_ctrl u_periph_pwr_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_valid(rd_valid), .sleep(sleep), .deep_sleep(deep_sleep),
    .dbg_attached(dbg_attached), .dom_ack(dom_ack), .mem_ack(mem_ack),
    .dom_req(dom_req), .mem_ret(mem_ret), .mem_off(mem_off),
    .mem_blk(mem_blk), .ldo_lp_en(ldo_lp_en)
  );

  // plant: acknowledges follow requests one cycle later unless frozen
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dom_ack <= 8'hFF;
      mem_ack <= 8'h00;
    end else if (!hold_ack) begin
      dom_ack <= dom_req;
      mem_ack <= mem_ret | mem_off;
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic chk(logic [7:0] act, logic [7:0] exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] bank, logic [2:0] slot, logic [7:0] d);
    wr_en = 1'b1; wr_addr = {bank, slot}; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] bank, logic [2:0] slot, logic [7:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_en = 1'b1; rd_addr = {bank, slot};
    step();
    rd_en = 1'b0;
  endtask

  // monitor: compares each returned read against the scoreboard
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R12 unexpected read actual=%h expected=none", rd_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rd_data, e, t);
      end
    end
  end

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; rd_en = 0; wr_addr = 0; rd_addr = 0; wr_data = 0;
    sleep = 0; deep_sleep = 0; dbg_attached = 0; hold_ack = 0;
    step(3);
    rst_n = 1'b1;
    step(2);

    chk(dom_req, 8'hFF, "R1 dom_req reset");
    chk(mem_ret | mem_off | mem_blk, 8'h00, "R1 mem outputs reset");
    rd(2'd1, 3'd4, 8'h01, "R1 R12 mode reset");
    rd(2'd2, 3'd4, 8'h00, "R1 R12 status reset");

    wr(2'd0, 3'd3, 8'h00);
    step(3);
    chk(dom_req, 8'hF7, "R2 phy domain off");
    rd(2'd2, 3'd3, 8'h02, "R2 R4 status off");
    rd(2'd0, 3'd3, 8'h00, "R2 R12 enable readback");

    wr(2'd0, 3'd6, 8'h00);
    step(3);
    chk({7'd0, dom_req[6]}, 8'h01, "R3 slot6 dom_req kept");
    rd(2'd0, 3'd6, 8'h01, "R3 slot6 readback");

    hold_ack = 1'b1;
    wr(2'd0, 3'd5, 8'h00);
    rd(2'd2, 3'd5, 8'h03, "R4 transitioning");
    hold_ack = 1'b0;
    step(3);
    rd(2'd2, 3'd5, 8'h02, "R4 settled off");

    sleep = 1'b1; #1;
    chk({7'd0, ldo_lp_en}, 8'h01, "R11 sleep no debugger");
    dbg_attached = 1'b1; #1;
    chk({7'd0, ldo_lp_en}, 8'h00, "R11 debugger blocks");
    sleep = 1'b0; dbg_attached = 1'b0; #1;
    chk({7'd0, ldo_lp_en}, 8'h00, "R11 run mode");

    wr(2'd1, 3'd4, 8'h01);
    wr(2'd1, 3'd0, 8'h01);
    wr(2'd1, 3'd1, 8'h00);
    wr(2'd1, 3'd2, 8'h00);
    deep_sleep = 1'b1;
    step(4);
    chk(mem_ret, 8'h10, "R6 R7 retention requests");
    chk(mem_off, 8'h00, "R7 R8 no off with emac domain on");
    chk(mem_blk, 8'h10, "R6 R7 block only usb");
    rd(2'd2, 3'd4, 8'h04, "R6 usb retained");
    rd(2'd2, 3'd0, 8'h00, "R7 can stays on");
    rd(2'd2, 3'd1, 8'h00, "R7 lcd stays on");

    wr(2'd1, 3'd0, 8'h00);
    step(2);
    chk(mem_off, 8'h00, "R5 write during deep-sleep not applied");

    deep_sleep = 1'b0;
    step();
    chk({7'd0, mem_blk[4]}, 8'h01, "R10 block at exit");
    chk(mem_ret, 8'h00, "R5 exit drops request");
    step();
    chk({7'd0, mem_blk[4]}, 8'h01, "R10 hold cycle");
    step();
    chk({7'd0, mem_blk[4]}, 8'h00, "R10 accessible");
    rd(2'd2, 3'd4, 8'h00, "R6 usb back on");

    wr(2'd0, 3'd2, 8'h00);
    wr(2'd1, 3'd4, 8'h00);
    step(2);
    deep_sleep = 1'b1;
    step(4);
    chk(mem_off, 8'h15, "R8 off on can emac usb");
    rd(2'd2, 3'd0, 8'h18, "R8 R9 can off invalid");
    rd(2'd2, 3'd2, 8'h1A, "R8 R9 emac off");
    deep_sleep = 1'b0;
    step(4);
    rd(2'd2, 3'd0, 8'h10, "R9 invalid kept after exit");
    wr(2'd2, 3'd0, 8'h01);
    rd(2'd2, 3'd0, 8'h00, "R9 invalid cleared");
    rd(2'd2, 3'd2, 8'h12, "R9 emac invalid kept");

    step(3);
    report();
  end

endmodule